// File: doc/BRIEF.md
# Table-Driven Duty Ramp Sequencer

This block produces a slowly changing PWM duty value by walking through a window of a small duty lookup table. A host loads the table through a simple write port, picks a window with a low and a high index, a per-entry dwell code, a direction, and optional loop and turn-around behaviour. It can also add an extra dwell at either end of the window. A slow timing tick, nominally 1 kHz, paces the walk. The resulting duty value feeds a separate PWM counter. A bypass input hands that counter a directly programmed duty value instead.

Typical uses are breathing and blinking indicator lights. A ping-pong walk with loop set gives a smooth breathe. A one-way walk with a long dwell at one end gives a blink. A single-entry window gives a steady level.

Top module: `duty_ramp_seq`

## Requirements
- R1: The table holds DEPTH (64) entries of DW (9) bits, all zero after reset. A write with `tbl_we_i` high stores `tbl_data_i` at `tbl_addr_i` on the clock edge. With bypass low, `duty_o` equals the entry at `idx_o`.
- R2: Step code c (0..15) selects a dwell of 0,1,2,3,4,6,8,16,18,24,32,36,64,128,256,512 ms for c = 0..15 in that order, counted in ticks. Each entry is held for that many ticks. Code 0 behaves as one tick per entry.
- R3: With `dir_up_i` = 1 the walk starts at the low index and moves +1 per step toward the high index. With 0 it starts at the high index and moves -1 toward the low index.
- R4: With reverse set, once the far end's dwell (and pause) is done the direction flips and the walk heads back one entry at a time. Without loop it stops on the starting end after the return leg.
- R5: With loop set and reverse clear, after the far end the index jumps back to the starting end and the walk repeats forever. With loop and reverse both set, the walk ping-pongs forever.
- R6: When the walk finishes the dwell on the end it was heading for, an enabled pause for that end (high end when moving up, low end when moving down) adds mult × dwell ticks. In that time the index stays put. For 6-bit pause code p, mult is p+1 for p ≤ 15; codes 16..56 give 23, 28, 31, 42, 47, 56, 63, 83, 94, 111, 125, 167, 188, 222, 250, 333, 375, 500, 667, 750, 800, 900, 1000, 1100, 1200, 1300, 1400, 1500, 1600, 1800, 2000, 2500, 3000, 3500, 4000, 4500, 5000, 5500, 6000, 6500, 7000; higher codes give 7000.
- R7: Without loop, the walk stops on the last entry reached and holds it for as long as the run lasts.
- R8: When the low and high indices are equal, the index and the output stay on that single entry.
- R9: With `bypass_i` high, `duty_o` equals `reg_duty_i`. The walk proceeds unchanged underneath.
- R10: The walk runs only while both `ramp_en_i` and `ramp_go_i` are high. Otherwise ticks are ignored and `idx_o` is the starting end, from the next clock onward.
- R11: Dropping either run bit returns the index to the starting end on the next clock and discards any dwell or pause in progress. A restart begins a fresh walk.
- R12: While running, `idx_o` changes only on clocks where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock pulse per millisecond time base |
| ramp_en_i | input | 1 | Ramp generator enable |
| ramp_go_i | input | 1 | Ramp start |
| bypass_i | input | 1 | Select `reg_duty_i` as output |
| reg_duty_i | input | DW | Directly programmed duty value |
| lo_idx_i | input | IW | Window low index |
| hi_idx_i | input | IW | Window high index |
| step_code_i | input | 4 | Dwell-per-entry code |
| dir_up_i | input | 1 | 1: walk upward first |
| loop_i | input | 1 | Repeat forever |
| reverse_i | input | 1 | Turn around at the far end |
| pause_hi_en_i | input | 1 | Enable pause at the high end |
| pause_hi_code_i | input | 6 | High-end pause multiplier code |
| pause_lo_en_i | input | 1 | Enable pause at the low end |
| pause_lo_code_i | input | 6 | Low-end pause multiplier code |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | IW | Table write address |
| tbl_data_i | input | DW | Table write data |
| duty_o | output | DW | Duty value to the PWM counter |
| idx_o | output | IW | Current table index |

## Verification
The bench builds the block at its default size: a 64-entry, 9-bit table. Every entry is written and then read back by parking the idle index on it. It then sweeps a five-entry window and a one-entry window over all combinations of direction, loop, reverse and the two pause enables, for the four shortest step codes. Each tick is compared with an arithmetic model, and each run is stopped at whatever point it has reached, often mid-pause. Separate runs reach the 64 ms and 512 ms dwells and the code-16 pause multiplier. One run sits out the full 7000-times pause.

// File: rtl/ramp_seq_pkg.sv
package ramp_seq_pkg;

    localparam int unsigned STEP_CODE_W    = 4;
    localparam int unsigned PAUSE_CODE_W   = 6;
    localparam int unsigned MAX_STEP_MS    = 512;
    localparam int unsigned MAX_PAUSE_MULT = 7000;
    localparam int unsigned STEP_W         = $clog2(MAX_STEP_MS + 1);
    localparam int unsigned MULT_W         = $clog2(MAX_PAUSE_MULT + 1);
    localparam int unsigned DWELL_W        = STEP_W + MULT_W;

    // Dwell per table entry in milliseconds, indexed by step code.
    function automatic logic [STEP_W-1:0] step_ms(input logic [STEP_CODE_W-1:0] code);
        logic [STEP_W-1:0] v;
        case (code)
            4'd0:    v = STEP_W'(0);
            4'd1:    v = STEP_W'(1);
            4'd2:    v = STEP_W'(2);
            4'd3:    v = STEP_W'(3);
            4'd4:    v = STEP_W'(4);
            4'd5:    v = STEP_W'(6);
            4'd6:    v = STEP_W'(8);
            4'd7:    v = STEP_W'(16);
            4'd8:    v = STEP_W'(18);
            4'd9:    v = STEP_W'(24);
            4'd10:   v = STEP_W'(32);
            4'd11:   v = STEP_W'(36);
            4'd12:   v = STEP_W'(64);
            4'd13:   v = STEP_W'(128);
            4'd14:   v = STEP_W'(256);
            default: v = STEP_W'(512);
        endcase
        return v;
    endfunction

    // End pause expressed as a multiple of the step dwell.
    function automatic logic [MULT_W-1:0] pause_mult(input logic [PAUSE_CODE_W-1:0] code);
        logic [MULT_W-1:0] v;
        if (code < PAUSE_CODE_W'(16)) begin
            v = MULT_W'(code) + MULT_W'(1);
        end else begin
            case (code)
                6'd16:   v = MULT_W'(23);
                6'd17:   v = MULT_W'(28);
                6'd18:   v = MULT_W'(31);
                6'd19:   v = MULT_W'(42);
                6'd20:   v = MULT_W'(47);
                6'd21:   v = MULT_W'(56);
                6'd22:   v = MULT_W'(63);
                6'd23:   v = MULT_W'(83);
                6'd24:   v = MULT_W'(94);
                6'd25:   v = MULT_W'(111);
                6'd26:   v = MULT_W'(125);
                6'd27:   v = MULT_W'(167);
                6'd28:   v = MULT_W'(188);
                6'd29:   v = MULT_W'(222);
                6'd30:   v = MULT_W'(250);
                6'd31:   v = MULT_W'(333);
                6'd32:   v = MULT_W'(375);
                6'd33:   v = MULT_W'(500);
                6'd34:   v = MULT_W'(667);
                6'd35:   v = MULT_W'(750);
                6'd36:   v = MULT_W'(800);
                6'd37:   v = MULT_W'(900);
                6'd38:   v = MULT_W'(1000);
                6'd39:   v = MULT_W'(1100);
                6'd40:   v = MULT_W'(1200);
                6'd41:   v = MULT_W'(1300);
                6'd42:   v = MULT_W'(1400);
                6'd43:   v = MULT_W'(1500);
                6'd44:   v = MULT_W'(1600);
                6'd45:   v = MULT_W'(1800);
                6'd46:   v = MULT_W'(2000);
                6'd47:   v = MULT_W'(2500);
                6'd48:   v = MULT_W'(3000);
                6'd49:   v = MULT_W'(3500);
                6'd50:   v = MULT_W'(4000);
                6'd51:   v = MULT_W'(4500);
                6'd52:   v = MULT_W'(5000);
                6'd53:   v = MULT_W'(5500);
                6'd54:   v = MULT_W'(6000);
                6'd55:   v = MULT_W'(6500);
                default: v = MULT_W'(7000);
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/ramp_lut_mem.sv
module ramp_lut_mem #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned DW    = 9,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o
);

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[wr_addr_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int e = 0; e < DEPTH; e++) begin
                mem_q[e] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/ramp_dwell_decode.sv
module ramp_dwell_decode
    import ramp_seq_pkg::*;
(
    input  logic [STEP_CODE_W-1:0]  step_code_i,
    input  logic [PAUSE_CODE_W-1:0] pause_code_i,
    output logic [STEP_W-1:0]       step_len_o,
    output logic [DWELL_W-1:0]      pause_len_o
);

    logic [STEP_W-1:0] ms;
    logic [MULT_W-1:0] mult;

    always_comb begin
        ms   = step_ms(step_code_i);
        mult = pause_mult(pause_code_i);
        // A zero dwell still needs one tick to move on.
        step_len_o  = (ms == '0) ? STEP_W'(1) : ms;
        pause_len_o = DWELL_W'(mult) * DWELL_W'(step_len_o);
    end

endmodule

// File: rtl/ramp_walker.sv
module ramp_walker
    import ramp_seq_pkg::*;
#(
    parameter int unsigned IW = 6
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic               tick_i,
    input  logic [IW-1:0]      lo_i,
    input  logic [IW-1:0]      hi_i,
    input  logic               dir_up_i,
    input  logic               loop_i,
    input  logic               reverse_i,
    input  logic               pause_hi_en_i,
    input  logic               pause_lo_en_i,
    input  logic [STEP_W-1:0]  step_len_i,
    input  logic [DWELL_W-1:0] pause_len_i,
    output logic [IW-1:0]      idx_o,
    output logic               up_o
);

    typedef struct packed {
        logic [IW-1:0]      idx;
        logic               up;
        logic               leg;
        logic               done;
        logic               pause;
        logic [DWELL_W-1:0] cnt;
    } walk_t;

    walk_t walk_d, walk_q;

    logic [IW-1:0]      target;
    logic [IW-1:0]      back_target;
    logic [DWELL_W-1:0] cnt_inc;
    logic [DWELL_W-1:0] step_ext;
    logic               end_pause_en;
    logic               finish;

    always_comb begin
        walk_d       = walk_q;
        target       = walk_q.up ? hi_i : lo_i;
        back_target  = walk_q.up ? lo_i : hi_i;
        cnt_inc      = walk_q.cnt + DWELL_W'(1);
        step_ext     = DWELL_W'(step_len_i);
        end_pause_en = walk_q.up ? pause_hi_en_i : pause_lo_en_i;
        finish       = 1'b0;

        if (!run_i) begin
            walk_d.idx   = dir_up_i ? lo_i : hi_i;
            walk_d.up    = dir_up_i;
            walk_d.leg   = 1'b0;
            walk_d.done  = 1'b0;
            walk_d.pause = 1'b0;
            walk_d.cnt   = '0;
        end else if (tick_i && !walk_q.done) begin
            if (walk_q.pause) begin
                if (cnt_inc >= pause_len_i) begin
                    walk_d.cnt   = '0;
                    walk_d.pause = 1'b0;
                    finish       = 1'b1;
                end else begin
                    walk_d.cnt = cnt_inc;
                end
            end else if (cnt_inc >= step_ext) begin
                walk_d.cnt = '0;
                if (walk_q.idx != target) begin
                    walk_d.idx = walk_q.up ? walk_q.idx + IW'(1) : walk_q.idx - IW'(1);
                end else if (end_pause_en) begin
                    walk_d.pause = 1'b1;
                end else begin
                    finish = 1'b1;
                end
            end else begin
                walk_d.cnt = cnt_inc;
            end

            if (finish) begin
                if (reverse_i) begin
                    if (!walk_q.leg || loop_i) begin
                        walk_d.up  = !walk_q.up;
                        walk_d.leg = !walk_q.leg;
                        if (walk_q.idx != back_target) begin
                            walk_d.idx = walk_q.up ? walk_q.idx - IW'(1) : walk_q.idx + IW'(1);
                        end
                    end else begin
                        walk_d.done = 1'b1;
                    end
                end else if (loop_i) begin
                    walk_d.idx = walk_q.up ? lo_i : hi_i;
                end else begin
                    walk_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign idx_o = walk_q.idx;
    assign up_o  = walk_q.up;

endmodule

// File: rtl/duty_ramp_seq.sv
module duty_ramp_seq
    import ramp_seq_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned DW    = 9,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    tick_i,
    input  logic                    ramp_en_i,
    input  logic                    ramp_go_i,
    input  logic                    bypass_i,
    input  logic [DW-1:0]           reg_duty_i,
    input  logic [IW-1:0]           lo_idx_i,
    input  logic [IW-1:0]           hi_idx_i,
    input  logic [STEP_CODE_W-1:0]  step_code_i,
    input  logic                    dir_up_i,
    input  logic                    loop_i,
    input  logic                    reverse_i,
    input  logic                    pause_hi_en_i,
    input  logic [PAUSE_CODE_W-1:0] pause_hi_code_i,
    input  logic                    pause_lo_en_i,
    input  logic [PAUSE_CODE_W-1:0] pause_lo_code_i,
    input  logic                    tbl_we_i,
    input  logic [IW-1:0]           tbl_addr_i,
    input  logic [DW-1:0]           tbl_data_i,
    output logic [DW-1:0]           duty_o,
    output logic [IW-1:0]           idx_o
);

    logic                    run;
    logic                    walk_up;
    logic [PAUSE_CODE_W-1:0] pause_code;
    logic [STEP_W-1:0]       step_len;
    logic [DWELL_W-1:0]      pause_len;
    logic [DW-1:0]           tbl_rd;

    assign run        = ramp_en_i & ramp_go_i;
    assign pause_code = walk_up ? pause_hi_code_i : pause_lo_code_i;

    ramp_lut_mem #(
        .DEPTH (DEPTH),
        .DW    (DW)
    ) i_lut (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (tbl_we_i),
        .wr_addr_i (tbl_addr_i),
        .wr_data_i (tbl_data_i),
        .rd_addr_i (idx_o),
        .rd_data_o (tbl_rd)
    );

    ramp_dwell_decode i_decode (
        .step_code_i  (step_code_i),
        .pause_code_i (pause_code),
        .step_len_o   (step_len),
        .pause_len_o  (pause_len)
    );

    ramp_walker #(
        .IW (IW)
    ) i_walker (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .run_i         (run),
        .tick_i        (tick_i),
        .lo_i          (lo_idx_i),
        .hi_i          (hi_idx_i),
        .dir_up_i      (dir_up_i),
        .loop_i        (loop_i),
        .reverse_i     (reverse_i),
        .pause_hi_en_i (pause_hi_en_i),
        .pause_lo_en_i (pause_lo_en_i),
        .step_len_i    (step_len),
        .pause_len_i   (pause_len),
        .idx_o         (idx_o),
        .up_o          (walk_up)
    );

    assign duty_o = bypass_i ? reg_duty_i : tbl_rd;

endmodule

// File: rtl/duty_ramp_seq_chk.sv
module duty_ramp_seq_chk #(
    parameter int unsigned IW = 6
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          tick_i,
    input logic          ramp_en_i,
    input logic          ramp_go_i,
    input logic          dir_up_i,
    input logic          loop_i,
    input logic          reverse_i,
    input logic [IW-1:0] lo_idx_i,
    input logic [IW-1:0] hi_idx_i,
    input logic [IW-1:0] idx_o
);

    logic run;
    assign run = ramp_en_i & ramp_go_i;

    // R12
    idx_only_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && !tick_i) |=> $stable(idx_o));

    // R10
    idle_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run |=> (idx_o == $past(dir_up_i ? lo_idx_i : hi_idx_i)));

    // R8
    single_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lo_idx_i == hi_idx_i) |=> (idx_o == $past(lo_idx_i)));

    // R7
    one_way_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && tick_i && dir_up_i && !loop_i && !reverse_i) |=> (idx_o >= $past(idx_o)));

endmodule

bind duty_ramp_seq duty_ramp_seq_chk #(.IW(IW)) i_duty_ramp_seq_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .ramp_en_i (ramp_en_i),
    .ramp_go_i (ramp_go_i),
    .dir_up_i  (dir_up_i),
    .loop_i    (loop_i),
    .reverse_i (reverse_i),
    .lo_idx_i  (lo_idx_i),
    .hi_idx_i  (hi_idx_i),
    .idx_o     (idx_o)
);

// File: tb/test_duty_ramp_seq.sv
module test_duty_ramp_seq;

    localparam int DEPTH = 64;
    localparam int DW    = 9;
    localparam int IW    = 6;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          tick_i = 1'b0;
    logic          ramp_en_i = 1'b0;
    logic          ramp_go_i = 1'b0;
    logic          bypass_i = 1'b0;
    logic [DW-1:0] reg_duty_i = '0;
    logic [IW-1:0] lo_idx_i = '0;
    logic [IW-1:0] hi_idx_i = '0;
    logic [3:0]    step_code_i = '0;
    logic          dir_up_i = 1'b0;
    logic          loop_i = 1'b0;
    logic          reverse_i = 1'b0;
    logic          pause_hi_en_i = 1'b0;
    logic [5:0]    pause_hi_code_i = '0;
    logic          pause_lo_en_i = 1'b0;
    logic [5:0]    pause_lo_code_i = '0;
    logic          tbl_we_i = 1'b0;
    logic [IW-1:0] tbl_addr_i = '0;
    logic [DW-1:0] tbl_data_i = '0;
    logic [DW-1:0] duty_o;
    logic [IW-1:0] idx_o;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    // model state
    int c_lo, c_hi, c_sc, c_up, c_lp, c_rv, c_phe, c_phc, c_ple, c_plc;
    int m_idx, m_up, m_leg, m_done, m_pause, m_cnt;

    always #2 clk = ~clk;

    duty_ramp_seq #(.DEPTH(DEPTH), .DW(DW)) i_duty_ramp_seq (
        .clk_i           (clk),
        .rst_ni          (rst_ni),
        .tick_i          (tick_i),
        .ramp_en_i       (ramp_en_i),
        .ramp_go_i       (ramp_go_i),
        .bypass_i        (bypass_i),
        .reg_duty_i      (reg_duty_i),
        .lo_idx_i        (lo_idx_i),
        .hi_idx_i        (hi_idx_i),
        .step_code_i     (step_code_i),
        .dir_up_i        (dir_up_i),
        .loop_i          (loop_i),
        .reverse_i       (reverse_i),
        .pause_hi_en_i   (pause_hi_en_i),
        .pause_hi_code_i (pause_hi_code_i),
        .pause_lo_en_i   (pause_lo_en_i),
        .pause_lo_code_i (pause_lo_code_i),
        .tbl_we_i        (tbl_we_i),
        .tbl_addr_i      (tbl_addr_i),
        .tbl_data_i      (tbl_data_i),
        .duty_o          (duty_o),
        .idx_o           (idx_o)
    );

    function automatic int tbl_val(input int i);
        return (i * 37 + 11) % 512;
    endfunction

    function automatic int ms_of(input int c);
        int lst [16] = '{0, 1, 2, 3, 4, 6, 8, 16, 18, 24, 32, 36, 64, 128, 256, 512};
        return lst[c];
    endfunction

    function automatic int mult_of(input int c);
        if (c < 16) return c + 1;
        if (c == 16) return 23;
        return 7000;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        int exp_duty;
        exp_duty = bypass_i ? int'(reg_duty_i) : tbl_val(m_idx);
        chk(int'(idx_o) == m_idx, tag, "index", int'(idx_o), m_idx);
        chk(int'(duty_o) == exp_duty, tag, "duty", int'(duty_o), exp_duty);
    endtask

    task automatic m_init();
        m_idx = c_up ? c_lo : c_hi;
        m_up = c_up;
        m_leg = 0;
        m_done = 0;
        m_pause = 0;
        m_cnt = 0;
    endtask

    task automatic m_finish();
        if (c_rv != 0) begin
            if (m_leg == 0 || c_lp != 0) begin
                m_up = 1 - m_up;
                m_leg = 1 - m_leg;
                if (m_up != 0) begin
                    if (m_idx != c_hi) m_idx = m_idx + 1;
                end else begin
                    if (m_idx != c_lo) m_idx = m_idx - 1;
                end
            end else begin
                m_done = 1;
            end
        end else if (c_lp != 0) begin
            m_idx = (c_up != 0) ? c_lo : c_hi;
        end else begin
            m_done = 1;
        end
    endtask

    task automatic m_tick();
        int slen;
        int plen;
        int tgt;
        slen = ms_of(c_sc);
        if (slen == 0) slen = 1;
        if (m_done != 0) return;
        if (m_pause != 0) begin
            plen = slen * mult_of((m_up != 0) ? c_phc : c_plc);
            if (m_cnt + 1 >= plen) begin
                m_cnt = 0;
                m_pause = 0;
                m_finish();
            end else begin
                m_cnt++;
            end
        end else if (m_cnt + 1 >= slen) begin
            m_cnt = 0;
            tgt = (m_up != 0) ? c_hi : c_lo;
            if (m_idx != tgt) m_idx = (m_up != 0) ? m_idx + 1 : m_idx - 1;
            else if (((m_up != 0) ? c_phe : c_ple) != 0) m_pause = 1;
            else m_finish();
        end else begin
            m_cnt++;
        end
    endtask

    task automatic do_tick(input string tag);
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) tick_i = 1'b0;
        m_tick();
        check_state(tag);
    endtask

    task automatic run_case(input int lo, input int hi, input int sc, input int up,
                            input int lp, input int rv, input int phe, input int phc,
                            input int ple, input int plc, input int nt, input string tag);
        c_lo = lo; c_hi = hi; c_sc = sc; c_up = up; c_lp = lp; c_rv = rv;
        c_phe = phe; c_phc = phc; c_ple = ple; c_plc = plc;
        lo_idx_i = IW'(lo);
        hi_idx_i = IW'(hi);
        step_code_i = 4'(sc);
        dir_up_i = up[0];
        loop_i = lp[0];
        reverse_i = rv[0];
        pause_hi_en_i = phe[0];
        pause_hi_code_i = 6'(phc);
        pause_lo_en_i = ple[0];
        pause_lo_code_i = 6'(plc);
        ramp_en_i = 1'b1;
        ramp_go_i = 1'b0;
        @(negedge clk);
        m_init();
        // R10: idle index sits on the starting end
        chk(int'(idx_o) == m_idx, "R10", "idle start", int'(idx_o), m_idx);
        ramp_go_i = 1'b1;
        @(negedge clk);
        check_state(tag);
        repeat (3) @(negedge clk);
        // R12: no tick, no movement
        chk(int'(idx_o) == m_idx, "R12", "idle hold", int'(idx_o), m_idx);
        for (int t = 0; t < nt; t++) begin
            do_tick(tag);
        end
        ramp_go_i = 1'b0;
        @(negedge clk);
        m_init();
        // R11: stop returns to the starting end
        chk(int'(idx_o) == m_idx, "R11", "stop to start", int'(idx_o), m_idx);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL R12 watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        string tag;
        repeat (4) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(idx_o == '0, "R1", "reset index", int'(idx_o), 0);
        chk(duty_o == '0, "R1", "reset duty", int'(duty_o), 0);

        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            tbl_we_i = 1'b1;
            tbl_addr_i = IW'(i);
            tbl_data_i = DW'(tbl_val(i));
        end
        @(negedge clk) tbl_we_i = 1'b0;

        // R1: every entry read back through the idle index
        dir_up_i = 1'b1;
        hi_idx_i = IW'(DEPTH - 1);
        for (int i = 0; i < DEPTH; i++) begin
            lo_idx_i = IW'(i);
            @(negedge clk);
            chk(int'(duty_o) == tbl_val(i), "R1", "table entry", int'(duty_o), tbl_val(i));
        end

        // R10: ticks ignored unless both run bits are set
        lo_idx_i = IW'(4); hi_idx_i = IW'(8); dir_up_i = 1'b0; step_code_i = 4'd0;
        ramp_en_i = 1'b0; ramp_go_i = 1'b1;
        repeat (5) begin
            @(negedge clk) tick_i = 1'b1;
            @(negedge clk) tick_i = 1'b0;
        end
        chk(int'(idx_o) == 8, "R10", "enable low", int'(idx_o), 8);
        ramp_en_i = 1'b1; ramp_go_i = 1'b0;
        repeat (5) begin
            @(negedge clk) tick_i = 1'b1;
            @(negedge clk) tick_i = 1'b0;
        end
        chk(int'(idx_o) == 8, "R10", "start low", int'(idx_o), 8);

        // main sweep: two windows, all control combinations, short step codes
        for (int w = 0; w < 2; w++) begin
            for (int sc = 0; sc < 4; sc++) begin
                for (int up = 0; up < 2; up++) begin
                    for (int lp = 0; lp < 2; lp++) begin
                        for (int rv = 0; rv < 2; rv++) begin
                            for (int pz = 0; pz < 4; pz++) begin
                                if (w == 1) tag = "R8";
                                else if (pz != 0) tag = "R6";
                                else if (rv != 0) tag = "R4";
                                else if (lp != 0) tag = "R5";
                                else tag = "R3";
                                run_case((w == 0) ? 5 : 12, (w == 0) ? 9 : 12, sc, up, lp, rv,
                                         pz & 1, 1, (pz >> 1) & 1, 0, 80, tag);
                            end
                        end
                    end
                end
            end
        end

        // R7: one-way walk parks on its last entry
        run_case(2, 5, 1, 1, 0, 0, 0, 0, 0, 0, 30, "R7");
        run_case(2, 5, 2, 0, 0, 1, 1, 2, 0, 0, 40, "R7");

        // R2: long dwell codes
        run_case(0, 2, 12, 1, 1, 0, 0, 0, 0, 0, 300, "R2");
        run_case(7, 8, 15, 1, 1, 0, 0, 0, 0, 0, 1100, "R2");
        run_case(20, 23, 0, 0, 1, 0, 0, 0, 0, 0, 12, "R2");

        // R6: code 16 multiplier and the longest multiplier
        run_case(0, 1, 1, 1, 1, 1, 1, 16, 1, 3, 120, "R6");
        run_case(3, 4, 0, 1, 1, 0, 1, 56, 0, 0, 7005, "R6");

        // R11: stop in the middle of a long pause, then restart fresh
        run_case(3, 4, 0, 1, 1, 0, 1, 56, 0, 0, 20, "R11");
        run_case(3, 4, 0, 1, 1, 0, 1, 56, 0, 0, 20, "R11");

        // R9: bypass selects the register value while the walk continues
        bypass_i = 1'b1;
        reg_duty_i = 9'h1A5;
        run_case(10, 14, 0, 1, 1, 1, 0, 0, 0, 0, 20, "R9");
        reg_duty_i = 9'h003;
        run_case(10, 14, 1, 0, 1, 0, 0, 0, 0, 0, 20, "R9");
        bypass_i = 1'b0;
        @(negedge clk);
        chk(int'(duty_o) == tbl_val(14), "R9", "bypass off", int'(duty_o), tbl_val(14));

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule